// File: doc/BRIEF.md
# Dual-Channel Disk Controller Address Decoder

This block sits in front of a two-channel disk controller that has two devices per channel. Each host I/O request is compared against five programmable windows, each set by a base and a size. The windows are the primary command, primary control, secondary command and secondary control blocks, plus one bus-master register block. For each request the block reports four things: the kind of window that was hit, the channel, the byte offset inside the window, and the index of the device the access targets.

Each channel keeps a one-bit shadow of its device-select choice. The shadow is loaded from writes to the drive/head register of that channel's command window. The device index is the channel number times two plus the shadow bit. The block also rejects some accesses: all of them when I/O decoding is switched off, bus-master writes when bus mastering is switched off, and accesses whose size does not suit the window. It does not forward anything to the devices, and it holds none of the controller's registers.

Top module: `ide_addr_decode`

## Requirements
- R1: Results for a request sampled with `req_valid` high appear on the outputs one clock later, with `out_valid` high. After reset `out_valid` is low, `out_region` is 3 (none) and every other output is 0.
- R2: The windows are tried in this fixed order, and the first hit wins: primary command (window 0), primary control (1), secondary command (2), secondary control (3), bus-master (4). A window whose base is zero never matches. `out_region` encodes the hit window's kind as 0 = command, 1 = control, 2 = bus-master, 3 = none.
- R3: Window k matches addresses A with base_k <= A < base_k + size_k. `out_offset` is A - base_k.
- R4: An address that matches no window sets `out_invalid` and gives region 3, channel 0, offset 0, device 0, and no accept.
- R5: Windows 0 and 1 belong to channel 0, and windows 2 and 3 to channel 1. In the bus-master window, offsets below 8 give channel 0 and offsets of 8 or more give channel 1.
- R6: An accepted write to command-window offset 6 loads that channel's select shadow from bit 4 of `req_wdata`, on that clock edge.
- R7: On a hit, `out_dev` = channel*2 + the channel's select bit. For a write that loads the shadow, the newly written bit is used.
- R8: While `io_en` is low, no access is accepted and no shadow changes.
- R9: A bus-master write is rejected while `bm_en` is low. Bus-master reads do not depend on `bm_en`.
- R10: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal. A hit with code 3, or with code 2 on a command or control window, sets `out_size_err` and is not accepted.
- R11: Reset clears both select shadows to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 8 | Low byte of write data |
| io_en | input | 1 | I/O decoding enabled |
| bm_en | input | 1 | Bus mastering enabled |
| win_base | input | 5*AW | Window bases, window k at bits k*AW upward |
| win_size | input | 5*AW | Window sizes, same packing |
| out_valid | output | 1 | Registered result valid |
| out_accept | output | 1 | Access accepted |
| out_invalid | output | 1 | No window matched |
| out_size_err | output | 1 | Size not allowed for the window |
| out_region | output | 2 | Window kind |
| out_channel | output | 1 | Channel, 0 = primary |
| out_offset | output | AW | Offset inside the window |
| out_dev | output | 2 | Target device index |

## Verification
Every decode result arrives one clock after the edge that samples the request. A shadow update takes effect on that same edge, so the next request already sees the new select bit. The bench drives each request on a falling edge, holds it across one rising edge, and compares all outputs at the following falling edge. It does this before starting the next request. The table vectors run in order so that shadow state carries from one vector to the next, and the later reads confirm which writes changed it and which did not.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int WIN_COUNT = 5;
  localparam int WIN_IDX_W = $clog2(WIN_COUNT);
  localparam int WIN_BM    = 4;

  typedef enum logic [1:0] {
    RGN_CMD  = 2'd0,
    RGN_CTRL = 2'd1,
    RGN_BM   = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_ILLEG = 2'd3;
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] offset
);
  logic [AW:0] lo_ext, hi_ext, a_ext;

  always_comb begin
    lo_ext = {1'b0, base};
    hi_ext = {1'b0, base} + {1'b0, size};
    a_ext  = {1'b0, addr};
    hit    = (base != '0) && (a_ext >= lo_ext) && (a_ext < hi_ext);
    offset = addr - base;
  end
endmodule

// File: rtl/ide_prio_pick.sv
module ide_prio_pick #(
  parameter int N  = 5,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    hits,
  input  logic [N*AW-1:0] offsets,
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [AW-1:0]   offset
);
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    offset = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any    = 1'b1;
        idx    = IW'(i);
        offset = offsets[i*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/ide_sel_shadow.sv
module ide_sel_shadow #(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd_en,
  input  logic [CHW-1:0] upd_ch,
  input  logic           upd_bit,
  output logic [NCH-1:0] sel
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (upd_en) sel[upd_ch] <= upd_bit;
    end
  end

  p_shadow_load_r6: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> sel[$past(upd_ch)] == $past(upd_bit));

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(upd_en)) |-> $stable(sel));
endmodule

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_dec_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BM_SPLIT = 8,
  parameter int SEL_OFF  = 6,
  parameter int SEL_BIT  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [1:0]            req_size,
  input  logic [7:0]            req_wdata,
  input  logic                  io_en,
  input  logic                  bm_en,
  input  logic [WIN_COUNT*AW-1:0] win_base,
  input  logic [WIN_COUNT*AW-1:0] win_size,
  output logic                  out_valid,
  output logic                  out_accept,
  output logic                  out_invalid,
  output logic                  out_size_err,
  output logic [1:0]            out_region,
  output logic                  out_channel,
  output logic [AW-1:0]         out_offset,
  output logic [1:0]            out_dev
);
  localparam int NCH = 2;

  logic [WIN_COUNT-1:0]    hits;
  logic [WIN_COUNT*AW-1:0] offs;
  logic                    hit_any;
  logic [WIN_IDX_W-1:0]    win_idx;
  logic [AW-1:0]           off;
  logic [NCH-1:0]          sel;

  genvar g;
  generate
    for (g = 0; g < WIN_COUNT; g++) begin : g_win
      ide_win_match #(.AW(AW)) u_match (
        .base   (win_base[g*AW +: AW]),
        .size   (win_size[g*AW +: AW]),
        .addr   (req_addr),
        .hit    (hits[g]),
        .offset (offs[g*AW +: AW])
      );
    end
  endgenerate

  ide_prio_pick #(.N(WIN_COUNT), .AW(AW)) u_pick (
    .hits    (hits),
    .offsets (offs),
    .any     (hit_any),
    .idx     (win_idx),
    .offset  (off)
  );

  logic      is_bm, ch, size_bad, bm_block, accept, sel_wr, dev_bit;
  region_e   region;
  logic [1:0] dev;

  always_comb begin
    is_bm    = hit_any && (win_idx == WIN_IDX_W'(WIN_BM));
    if (!hit_any)   ch = 1'b0;
    else if (is_bm) ch = (off >= AW'(BM_SPLIT));
    else            ch = win_idx[1];
    if (!hit_any)   region = RGN_NONE;
    else if (is_bm) region = RGN_BM;
    else            region = win_idx[0] ? RGN_CTRL : RGN_CMD;
    size_bad = hit_any && ((req_size == SZ_ILLEG) ||
                           ((req_size == SZ_WORD) && !is_bm));
    bm_block = is_bm && req_write && !bm_en;
    accept   = req_valid && hit_any && io_en && !size_bad && !bm_block;
    sel_wr   = accept && req_write && (region == RGN_CMD) &&
               (off == AW'(SEL_OFF));
    dev_bit  = sel_wr ? req_wdata[SEL_BIT] : sel[ch];
    dev      = hit_any ? {ch, dev_bit} : 2'd0;
  end

  ide_sel_shadow #(.NCH(NCH)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (sel_wr),
    .upd_ch  (ch),
    .upd_bit (req_wdata[SEL_BIT]),
    .sel     (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_accept   <= 1'b0;
      out_invalid  <= 1'b0;
      out_size_err <= 1'b0;
      out_region   <= RGN_NONE;
      out_channel  <= 1'b0;
      out_offset   <= '0;
      out_dev      <= '0;
    end else begin
      out_valid    <= req_valid;
      out_accept   <= accept;
      out_invalid  <= req_valid && !hit_any;
      out_size_err <= req_valid && size_bad;
      if (req_valid) begin
        out_region  <= region;
        out_channel <= ch;
        out_offset  <= hit_any ? off : '0;
        out_dev     <= dev;
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (out_valid == $past(req_valid)));

  p_miss_clean_r4: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (out_region == RGN_NONE) && !out_accept && (out_dev == 2'd0));

  p_io_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && out_accept) |-> $past(io_en));

  p_bm_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && out_valid && out_region == RGN_BM && $past(req_write) && !$past(bm_en))
      |-> !out_accept);

  p_size_rule_r10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && out_accept && out_region != RGN_BM) |-> ($past(req_size) < SZ_WORD));
endmodule

// File: tb/ide_addr_decode_tb.sv
module ide_addr_decode_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, io_en, bm_en;
  logic [AW-1:0] req_addr;
  logic [1:0] req_size;
  logic [7:0] req_wdata;
  logic [5*AW-1:0] win_base, win_size;
  logic out_valid, out_accept, out_invalid, out_size_err, out_channel;
  logic [1:0] out_region, out_dev;
  logic [AW-1:0] out_offset;

  always #4 clk = ~clk;

  ide_addr_decode #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .io_en(io_en), .bm_en(bm_en), .win_base(win_base), .win_size(win_size),
    .out_valid(out_valid), .out_accept(out_accept), .out_invalid(out_invalid),
    .out_size_err(out_size_err), .out_region(out_region),
    .out_channel(out_channel), .out_offset(out_offset), .out_dev(out_dev)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [1:0]  sz;
    logic [7:0]  wd;
    logic        io;
    logic        bm;
    logic        acc;
    logic        inv;
    logic [1:0]  rgn;
    logic        ch;
    logic [15:0] off;
    logic [1:0]  dev;
    logic        serr;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,16'h01F0,2'd0,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b0,16'h0,2'd0,1'b0}, // R3 base
    '{1'b1,16'h01F6,2'd0,8'h10,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b0,16'h6,2'd1,1'b0}, // R6 R7 load 1
    '{1'b0,16'h01F2,2'd1,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b0,16'h2,2'd1,1'b0}, // R7 shadow used
    '{1'b0,16'h0172,2'd0,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b1,16'h2,2'd2,1'b0}, // R5 secondary
    '{1'b1,16'h0176,2'd0,8'hB0,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b1,16'h6,2'd3,1'b0}, // R6 secondary load
    '{1'b0,16'h03F6,2'd1,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd1,1'b0,16'h2,2'd1,1'b0}, // R2 ctrl
    '{1'b0,16'h0376,2'd0,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd1,1'b1,16'h2,2'd3,1'b0},
    '{1'b0,16'hC002,2'd2,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd2,1'b0,16'h2,2'd1,1'b0}, // R9 read, R10 word ok
    '{1'b0,16'hC00A,2'd0,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd2,1'b1,16'hA,2'd3,1'b0}, // R5 split
    '{1'b1,16'hC000,2'd0,8'h00,1'b1,1'b0, 1'b0,1'b0,2'd2,1'b0,16'h0,2'd1,1'b0}, // R9 write blocked
    '{1'b1,16'hC008,2'd0,8'h00,1'b1,1'b1, 1'b1,1'b0,2'd2,1'b1,16'h8,2'd3,1'b0}, // R9 write allowed
    '{1'b0,16'h01F0,2'd2,8'h00,1'b1,1'b0, 1'b0,1'b0,2'd0,1'b0,16'h0,2'd1,1'b1}, // R10 word on cmd
    '{1'b1,16'h01F6,2'd0,8'h00,1'b0,1'b1, 1'b0,1'b0,2'd0,1'b0,16'h6,2'd1,1'b0}, // R8 io off
    '{1'b0,16'h01F0,2'd0,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b0,16'h0,2'd1,1'b0}, // R8 shadow kept
    '{1'b0,16'h0100,2'd0,8'h00,1'b1,1'b0, 1'b0,1'b1,2'd3,1'b0,16'h0,2'd0,1'b0}, // R4 miss
    '{1'b1,16'h01F6,2'd0,8'hEF,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b0,16'h6,2'd0,1'b0}, // R6 load 0
    '{1'b0,16'h01F7,2'd0,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd0,1'b0,16'h7,2'd0,1'b0}, // R3 top
    '{1'b0,16'h01F8,2'd0,8'h00,1'b1,1'b0, 1'b0,1'b1,2'd3,1'b0,16'h0,2'd0,1'b0}, // R3 end excl
    '{1'b0,16'hC00F,2'd0,8'h00,1'b1,1'b0, 1'b1,1'b0,2'd2,1'b1,16'hF,2'd3,1'b0},
    '{1'b1,16'h01F0,2'd3,8'h00,1'b1,1'b1, 1'b0,1'b0,2'd0,1'b0,16'h0,2'd0,1'b1}  // R10 illegal code
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [7:0] wd, input logic io, input logic bm);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = wd; io_en = io; bm_en = bm;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_std_windows();
    win_base = {16'hC000, 16'h0374, 16'h0170, 16'h03F4, 16'h01F0};
    win_size = {16'd16, 16'd4, 16'd8, 16'd4, 16'd8};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; io_en = 1'b0; bm_en = 1'b0;
    set_std_windows();
    do_reset();

    // R1 reset state
    chk("R1", out_valid, 0, "reset valid");
    chk("R1", out_region, 3, "reset region");
    chk("R1", {out_accept, out_invalid, out_size_err, out_channel}, 0, "reset flags");
    chk("R1", out_dev, 0, "reset dev");

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].wr, TBL[i].addr, TBL[i].sz, TBL[i].wd, TBL[i].io, TBL[i].bm);
      chk("R1", out_valid, 1, $sformatf("vec %0d valid", i));
      chk("R8", out_accept, TBL[i].acc, $sformatf("vec %0d accept", i));
      chk("R4", out_invalid, TBL[i].inv, $sformatf("vec %0d invalid", i));
      chk("R2", out_region, TBL[i].rgn, $sformatf("vec %0d region", i));
      chk("R5", out_channel, TBL[i].ch, $sformatf("vec %0d channel", i));
      chk("R3", out_offset, TBL[i].off, $sformatf("vec %0d offset", i));
      chk("R7", out_dev, TBL[i].dev, $sformatf("vec %0d dev", i));
      chk("R10", out_size_err, TBL[i].serr, $sformatf("vec %0d size err", i));
    end

    // R1 idle cycle drops valid
    @(negedge clk);
    chk("R1", out_valid, 0, "idle valid");

    // R2 priority: secondary control overlapped onto secondary command
    win_base[3*AW +: AW] = 16'h0170;
    issue(1'b0, 16'h0171, 2'd0, 8'h00, 1'b1, 1'b0);
    chk("R2", out_region, 0, "overlap region");
    chk("R2", out_channel, 1, "overlap channel");
    // R2 priority: primary command beats a later overlapping window
    win_base[3*AW +: AW] = 16'h01F0;
    issue(1'b0, 16'h01F1, 2'd0, 8'h00, 1'b1, 1'b0);
    chk("R2", {out_region, out_channel}, 0, "overlap primary");
    set_std_windows();

    // R2 zero base never matches
    win_base[0 +: AW] = 16'h0000;
    issue(1'b0, 16'h0002, 2'd0, 8'h00, 1'b1, 1'b0);
    chk("R2", out_invalid, 1, "zero base miss");
    set_std_windows();

    // R11 shadows cleared by reset: first load channel 1 select, then reset
    issue(1'b1, 16'h0176, 2'd0, 8'h10, 1'b1, 1'b0);
    do_reset();
    issue(1'b0, 16'h0170, 2'd0, 8'h00, 1'b1, 1'b0);
    chk("R11", out_dev, 2, "dev after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule